// File: doc/BRIEF.md
# Double-Buffered Serial Converter Input Logic

This block is the digital front end of a 12-bit serial-input digital-to-analog converter. A three-wire port (serial clock, serial data, active-low load strobe) moves a word, most significant bit first, into an input shift register. A second register, the converter code register, copies the shift register while the load strobe is held low and keeps its value while the strobe is high. Its contents are the parallel code that would steer the analog ladder. The ladder itself is not part of this block.

All three serial-port pins are asynchronous to the chip. They pass through synchronizers into the system clock domain. A rising edge of the serial clock is detected there, and the data bit from the same synchronizer depth is taken. The transparent code register is built as a clock-enabled flop whose enable is the synchronized load level. An active-low clear pin and an active-low power-on reset both force the shift register and the code register to zero at once, without waiting for a clock edge. Clear wins over load.

Top module: `serdac_frontend`

## Requirements
- R1: While `porRstN` is low, `shiftWord` and `dacCode` are both 0x000.
- R2: Each rising edge of `sclkIn` shifts the value of `sdataIn` present at that edge into bit 0 of `shiftWord`, and moves the older bits one position toward bit 11. After 12 edges, the first bit sent sits in bit 11 (most significant bit first).
- R3: While `loadN` is high, `dacCode` keeps its value, even when `shiftWord` changes.
- R4: While `loadN` is low, `dacCode` follows `shiftWord`, lagging by at most four system clock cycles. When `loadN` goes high, `dacCode` holds the last word it followed.
- R5: Driving `clrN` low sets `dacCode` and `shiftWord` to 0x000 right away, with no system clock edge needed.
- R6: While `clrN` is low, `dacCode` and `shiftWord` stay 0x000, even if `loadN` is low and `sclkIn` is toggling.
- R7: If more than 12 bits are shifted in, `shiftWord` keeps only the last 12 bits.
- R8: A falling edge of `sclkIn`, and any change of `sdataIn` while `sclkIn` holds its level, leave `shiftWord` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial pins are sampled in this domain |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| clrN | input | 1 | Clear, active low, asynchronous; tie high when unused |
| sclkIn | input | 1 | Serial clock; data is taken on its rising edge |
| sdataIn | input | 1 | Serial data, most significant bit first |
| loadN | input | 1 | Load strobe, active low; the code register is transparent while it is low |
| shiftWord | output | 12 | Contents of the input shift register |
| dacCode | output | 12 | Contents of the converter code register |

## Verification
The hardest case to reach is the transparent window: the code register must follow the shift register bit by bit while serial clocks are still arriving. The bench holds the load strobe low across a whole word and compares `dacCode` with the partly shifted word between serial edges. Clear is driven between two system clock edges, and the outputs are read before the next edge, so an implementation with a synchronous clear is caught. The priority case holds clear and load low together while a full word is clocked.

// File: rtl/serdac_pkg.sv
package serdac_pkg;

  // Strobes sent from the control path to the datapath, one system cycle each
  typedef struct packed {
    logic shiftEn;   // a synchronized serial-clock rising edge was seen
    logic shiftBit;  // serial data bit aligned with that edge
    logic latchEn;   // synchronized load level: code register is transparent
  } strobes_t;

endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
  parameter int  STAGES    = 2,
  parameter bit  RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/serdac_ctrl.sv
module serdac_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 porRstN,
  input  logic                 sclkIn,
  input  logic                 sdataIn,
  input  logic                 loadN,
  output serdac_pkg::strobes_t strobes
);

  localparam int NUM_PINS = 3;
  localparam logic [NUM_PINS-1:0] PIN_IDLE = 3'b100;  // load idles high

  logic [NUM_PINS-1:0] pinRaw;
  logic [NUM_PINS-1:0] pinSync;
  logic                sclkPrev;

  assign pinRaw = {loadN, sdataIn, sclkIn};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_sync
    serdac_sync #(
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(PIN_IDLE[p])
    ) u_sync (
      .clk    (clk),
      .rstN   (porRstN),
      .asyncIn(pinRaw[p]),
      .syncOut(pinSync[p])
    );
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) sclkPrev <= 1'b0;
    else          sclkPrev <= pinSync[0];
  end

  always_comb begin
    strobes.shiftEn  = pinSync[0] & ~sclkPrev;
    strobes.shiftBit = pinSync[1];
    strobes.latchEn  = ~pinSync[2];
  end

endmodule

// File: rtl/serdac_datapath.sv
module serdac_datapath #(
  parameter int WIDTH = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  serdac_pkg::strobes_t strobes,
  output logic [WIDTH-1:0]     shiftWord,
  output logic [WIDTH-1:0]     dacCode
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftWord <= '0;
    else if (strobes.shiftEn) shiftWord <= {shiftWord[WIDTH-2:0], strobes.shiftBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dacCode <= '0;
    else if (strobes.latchEn) dacCode <= shiftWord;
  end

endmodule

// File: rtl/serdac_frontend.sv
module serdac_frontend #(
  parameter int WIDTH       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic             clrN,
  input  logic             sclkIn,
  input  logic             sdataIn,
  input  logic             loadN,
  output logic [WIDTH-1:0] shiftWord,
  output logic [WIDTH-1:0] dacCode
);

  serdac_pkg::strobes_t strobes;
  logic                 dataRstN;

  // either reset source clears the registers; clear therefore beats load
  assign dataRstN = porRstN & clrN;

  serdac_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .porRstN(porRstN),
    .sclkIn (sclkIn),
    .sdataIn(sdataIn),
    .loadN  (loadN),
    .strobes(strobes)
  );

  serdac_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (dataRstN),
    .strobes  (strobes),
    .shiftWord(shiftWord),
    .dacCode  (dacCode)
  );

endmodule

// File: rtl/serdac_frontend_chk.sv
module serdac_frontend_chk #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             porRstN,
  input logic             clrN,
  input logic             shiftEn,
  input logic             shiftBit,
  input logic             latchEn,
  input logic [WIDTH-1:0] shiftWord,
  input logic [WIDTH-1:0] dacCode
);

  // R5, R6: clear forces both registers to zero
  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!porRstN)
    !clrN |-> (dacCode == '0 && shiftWord == '0));

  // R2, R7: an edge strobe shifts one bit in at bit 0
  assert_shift_step_R2: assert property (@(posedge clk) disable iff (!porRstN || !clrN)
    shiftEn |=> shiftWord == {$past(shiftWord[WIDTH-2:0]), $past(shiftBit)});

  // R8: without an edge strobe the shift register holds
  assert_shift_hold_R8: assert property (@(posedge clk) disable iff (!porRstN || !clrN)
    !shiftEn |=> $stable(shiftWord));

  // R3: code register holds while load is inactive
  assert_code_hold_R3: assert property (@(posedge clk) disable iff (!porRstN || !clrN)
    !latchEn |=> $stable(dacCode));

  // R4: code register copies the shift register while transparent
  assert_code_follow_R4: assert property (@(posedge clk) disable iff (!porRstN || !clrN)
    latchEn |=> dacCode == $past(shiftWord));

endmodule

bind serdac_frontend serdac_frontend_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .porRstN  (porRstN),
  .clrN     (clrN),
  .shiftEn  (strobes.shiftEn),
  .shiftBit (strobes.shiftBit),
  .latchEn  (strobes.latchEn),
  .shiftWord(shiftWord),
  .dacCode  (dacCode)
);

// File: tb/serdac_frontend_bench.sv
module serdac_frontend_bench;

  localparam int W = 12;

  logic         clk = 1'b0;
  logic         porRstN = 1'b0;
  logic         clrN = 1'b1;
  logic         sclkIn = 1'b0;
  logic         sdataIn = 1'b0;
  logic         loadN = 1'b1;
  logic [W-1:0] shiftWord;
  logic [W-1:0] dacCode;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  serdac_frontend u_serdac_frontend (
    .clk(clk), .porRstN(porRstN), .clrN(clrN), .sclkIn(sclkIn),
    .sdataIn(sdataIn), .loadN(loadN), .shiftWord(shiftWord), .dacCode(dacCode)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk);
    sdataIn = b;
    idle(4);
    sclkIn = 1'b1;
    idle(4);
    sclkIn = 1'b0;
  endtask

  task automatic sendWord(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) sendBit(w[i]);
    idle(6);
  endtask

  task automatic pulseLoad();
    @(negedge clk);
    loadN = 1'b0;
    idle(6);
    loadN = 1'b1;
    idle(6);
  endtask

  task automatic testReset();
    idle(3);
    check("R1 shiftWord in reset", shiftWord, 12'h000);
    check("R1 dacCode in reset", dacCode, 12'h000);
    porRstN = 1'b1;
    idle(3);
  endtask

  task automatic testShiftAndLoad();
    sendWord(12'hA5C);
    check("R2 shifted word", shiftWord, 12'hA5C);
    check("R3 code held before load", dacCode, 12'h000);
    pulseLoad();
    check("R4 code after load", dacCode, 12'hA5C);
    sendWord(12'h3F1);
    check("R2 second word", shiftWord, 12'h3F1);
    check("R3 code held while shifting", dacCode, 12'hA5C);
  endtask

  task automatic testTransparent();
    logic [W-1:0] exp;
    exp = 12'h3F1;
    @(negedge clk);
    loadN = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      sendBit(i[0]);
      exp = {exp[W-2:0], i[0]};
      idle(6);
      if (i == 8 || i == 2) check("R4 code follows shift mid-word", dacCode, exp);
    end
    loadN = 1'b1;
    idle(6);
    check("R4 code holds after load release", dacCode, 12'hAAA);
    sendWord(12'h0F0);
    check("R3 code unchanged by later word", dacCode, 12'hAAA);
  endtask

  task automatic testOverrun();
    logic [15:0] w;
    w = 16'hBEEF;
    for (int i = 15; i >= 0; i--) sendBit(w[i]);
    idle(6);
    check("R7 only last 12 bits kept", shiftWord, 12'hEEF);
  endtask

  task automatic testEdgeOnly();
    @(negedge clk);
    sdataIn = 1'b0;
    idle(4);
    sclkIn = 1'b1;
    idle(6);
    for (int i = 0; i < 10; i++) begin
      sdataIn = ~sdataIn;
      idle(2);
    end
    sclkIn = 1'b0;
    idle(6);
    for (int i = 0; i < 10; i++) begin
      sdataIn = ~sdataIn;
      idle(2);
    end
    check("R8 one shift per rising edge only", shiftWord, 12'hDDE);
  endtask

  task automatic testClear();
    pulseLoad();
    check("R4 code loaded before clear", dacCode, 12'hDDE);
    @(negedge clk);
    #1 clrN = 1'b0;
    #1;
    check("R5 code cleared without clock", dacCode, 12'h000);
    check("R5 shift cleared without clock", shiftWord, 12'h000);
    loadN = 1'b0;
    sendWord(12'h123);
    check("R6 shift stays zero under clear", shiftWord, 12'h000);
    check("R6 code stays zero under clear and load", dacCode, 12'h000);
    loadN = 1'b1;
    clrN = 1'b1;
    idle(4);
    sendWord(12'h123);
    pulseLoad();
    check("R4 load works after clear", dacCode, 12'h123);
  endtask

  task automatic testPor();
    @(negedge clk);
    #1 porRstN = 1'b0;
    #1;
    check("R1 shift cleared by power-on reset", shiftWord, 12'h000);
    check("R1 code cleared by power-on reset", dacCode, 12'h000);
  endtask

  initial begin
    testReset();
    testShiftAndLoad();
    testTransparent();
    testOverrun();
    testEdgeOnly();
    testClear();
    testPor();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule